// File: doc/BRIEF.md
# GPU L2 Line Coherence Controller

This block holds the coherence state of every line tracked by one slice of a shared GPU second-level cache. That cache sits between many first-level clients and a memory directory. Three event sources arrive each cycle: invalidating probes, downstream responses (fill data or write acknowledges) and client requests (read, write, atomic). The block picks one event, looks up the state of the addressed line, and in the same cycle drives the next state, a set of action strobes and a stall flag. The new state is committed on the next clock edge. The tag array, data array and network queues sit outside the block. They act on the strobes.

A static mode input selects write-back or write-through handling of client writes. In write-back mode, a write to a line that has no room is turned into a replacement of a victim line named by the tag logic, and the write stays queued. Atomics always bypass the cache. Probes are always answered without data. A per-line counter tracks the clients waiting on a fill, or the atomics still in flight.

State codes on the state ports: I=0, V=1, M=2, W=3, IV=4, WI=5, A=6. Request kind codes: 0 read, 1 write, 2 atomic. Response kind: 0 fill, 1 write acknowledge. Downstream kind: 0 none, 1 read, 2 write, 3 atomic.

Top module: `gl2_line_ctrl`

## Requirements
- R1: After reset every line is in I (code 0). With no input valid, no queue is popped, no stall is raised and the next state equals the current state. A committed next state is the current state seen by the next event on that line.
- R2: One event is taken per cycle. A probe wins over a response, and a response wins over a client request. Only the chosen source's pop may assert, and a probe is always popped.
- R3: A read in M or V pops, reads the tag, sends data to one client and marks the line MRU. A read in W starts a write-back and moves to WI without popping.
- R4: A read in I pops, sends a downstream read (kind 1) and moves to IV. A read in IV pops without a downstream request. A fill in IV allocates, writes the fill, marks MRU, moves to V and sends data with fanout equal to the number of reads taken while the line was in IV.
- R5: An atomic in I or V forwards an atomic (kind 3), invalidates a V line and moves to A. An atomic in A forwards and pops. An atomic in M or W writes back and moves to WI without popping. Each fill in A returns one result, and the fill for the last outstanding atomic moves the line to I.
- R6: In write-through mode, a write in I is only forwarded (kind 2) and popped. A write in V is merged locally, marked MRU and forwarded, and the line stays in V.
- R7: In write-back mode with room, a write is acknowledged at once, merged and popped. I allocates and moves to W, V and M move to M, and W stays in W.
- R8: In write-back mode without room, the event is a replacement on the victim line and the request is not popped. M or W writes back, invalidates and moves to WI. V invalidates and moves to I. I stays in I.
- R9: A probe always gives a reply that carries no data and starts no write-back. V moves to I, M moves to W, and I, W and the transient states are unchanged.
- R10: Client requests stall in WI. Reads and writes stall in A. Writes and atomics stall in IV. A stalled request reads no tag, is not popped and leaves the state unchanged.
- R11: A write acknowledge in WI is popped and moves the line to I. In I, V, IV or A it is popped and relayed to the client.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode_i | input | 1 | 1 = write-back mode, 0 = write-through mode (static) |
| prb_valid_i | input | 1 | Invalidating probe pending |
| prb_line_i | input | LINE_W | Probe line index |
| rsp_valid_i | input | 1 | Downstream response pending |
| rsp_ack_i | input | 1 | 1 = write acknowledge, 0 = fill data |
| rsp_line_i | input | LINE_W | Response line index |
| req_valid_i | input | 1 | Client request pending |
| req_kind_i | input | 2 | 0 read, 1 write, 2 atomic |
| req_line_i | input | LINE_W | Request line index |
| req_room_i | input | 1 | Line present or a free way exists |
| req_victim_i | input | LINE_W | Victim line when there is no room |
| evt_line_o | output | LINE_W | Line the chosen event acts on |
| cur_state_o | output | 3 | State of that line before the event |
| nxt_state_o | output | 3 | State committed at the next edge |
| pop_prb_o | output | 1 | Pop the probe queue |
| pop_rsp_o | output | 1 | Pop the response queue |
| pop_req_o | output | 1 | Pop the request queue |
| stall_o | output | 1 | Chosen request stalls |
| repl_o | output | 1 | Event is a replacement on the victim |
| tag_rd_o | output | 1 | Tag array read |
| send_data_o | output | 1 | Send data to clients |
| fanout_o | output | CNT_W | Number of clients served by send_data_o |
| ack_client_o | output | 1 | Write acknowledge to a client |
| down_kind_o | output | 2 | Downstream request kind |
| wb_o | output | 1 | Write the line back downstream |
| inval_o | output | 1 | Drop the cached copy |
| alloc_o | output | 1 | Allocate a way |
| merge_o | output | 1 | Merge written bytes into the line |
| fill_wr_o | output | 1 | Write fill data into the line |
| mru_o | output | 1 | Mark line most recently used |
| prb_reply_o | output | 1 | Send a dataless probe reply |

## Verification
A wrong stored state shows at the ports on the next event to the same line: cur_state_o differs, and the strobes go wrong with it. A read to a line wrongly left in V returns data when a write-back was due. A lost IV shows up as a repeated downstream read. A wrong waiter or atomic count shows on the next fill, as a wrong fanout or as a line leaving A too early or too late. The bench therefore returns to each line a cycle or a few cycles after every transition, so a corrupted state is seen within one event.

// File: rtl/gl2_pkg.sv
package gl2_pkg;

  typedef enum logic [2:0] {
    LS_I  = 3'd0,
    LS_V  = 3'd1,
    LS_M  = 3'd2,
    LS_W  = 3'd3,
    LS_IV = 3'd4,
    LS_WI = 3'd5,
    LS_A  = 3'd6
  } lstate_e;

  typedef enum logic [2:0] {
    EV_NONE, EV_READ, EV_WRITE, EV_ATOM, EV_FILL, EV_WACK, EV_PROBE, EV_REPL
  } evt_e;

  typedef enum logic [1:0] {SRC_NONE, SRC_PRB, SRC_RSP, SRC_REQ} src_e;

  typedef enum logic [1:0] {
    DN_NONE  = 2'd0,
    DN_READ  = 2'd1,
    DN_WRITE = 2'd2,
    DN_ATOM  = 2'd3
  } down_e;

  typedef enum logic [2:0] {CN_KEEP, CN_ONE, CN_INC, CN_DEC, CN_CLR} cnt_op_e;

  localparam logic [1:0] RQ_READ  = 2'd0;
  localparam logic [1:0] RQ_WRITE = 2'd1;
  localparam logic [1:0] RQ_ATOM  = 2'd2;

  typedef struct packed {
    logic  pop;
    logic  stall;
    logic  tag_rd;
    logic  send_data;
    logic  fan_cnt;
    logic  ack;
    logic  wb;
    logic  inval;
    logic  alloc;
    logic  merge;
    logic  fill_wr;
    logic  mru;
    logic  prb_reply;
    down_e down;
  } act_t;

endpackage

// File: rtl/gl2_evt_sel.sv
module gl2_evt_sel
  import gl2_pkg::*;
#(
  parameter int LINE_W = 4
) (
  input  logic              wb_mode_i,
  input  logic              prb_valid_i,
  input  logic [LINE_W-1:0] prb_line_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_ack_i,
  input  logic [LINE_W-1:0] rsp_line_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [LINE_W-1:0] req_line_i,
  input  logic              req_room_i,
  input  logic [LINE_W-1:0] req_victim_i,
  output evt_e              evt_o,
  output src_e              src_o,
  output logic [LINE_W-1:0] line_o
);

  always_comb begin
    evt_o  = EV_NONE;
    src_o  = SRC_NONE;
    line_o = '0;
    if (prb_valid_i) begin
      evt_o  = EV_PROBE;
      src_o  = SRC_PRB;
      line_o = prb_line_i;
    end else if (rsp_valid_i) begin
      evt_o  = rsp_ack_i ? EV_WACK : EV_FILL;
      src_o  = SRC_RSP;
      line_o = rsp_line_i;
    end else if (req_valid_i) begin
      src_o  = SRC_REQ;
      line_o = req_line_i;
      case (req_kind_i)
        RQ_READ: evt_o = EV_READ;
        RQ_ATOM: evt_o = EV_ATOM;
        RQ_WRITE: begin
          if (wb_mode_i && !req_room_i) begin
            evt_o  = EV_REPL;
            line_o = req_victim_i;
          end else begin
            evt_o = EV_WRITE;
          end
        end
        default: evt_o = EV_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gl2_line_fsm.sv
module gl2_line_fsm
  import gl2_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  evt_e             evt_i,
  input  lstate_e          cur_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wb_mode_i,
  output lstate_e          nxt_o,
  output act_t             act_o,
  output cnt_op_e          cnt_op_o
);

  logic busy;
  logic dirty;

  assign busy  = (cur_i == LS_IV) || (cur_i == LS_WI) || (cur_i == LS_A);
  assign dirty = (cur_i == LS_M) || (cur_i == LS_W);

  always_comb begin
    nxt_o    = cur_i;
    act_o    = '0;
    cnt_op_o = CN_KEEP;
    case (evt_i)
      EV_PROBE: begin
        act_o.pop       = 1'b1;
        act_o.prb_reply = 1'b1;
        act_o.tag_rd    = !busy;
        if (cur_i == LS_V) begin
          nxt_o       = LS_I;
          act_o.inval = 1'b1;
        end else if (cur_i == LS_M) begin
          nxt_o = LS_W;
        end
      end
      EV_FILL: begin
        act_o.pop = 1'b1;
        if (cur_i == LS_IV) begin
          act_o.tag_rd    = 1'b1;
          act_o.alloc     = 1'b1;
          act_o.fill_wr   = 1'b1;
          act_o.mru       = 1'b1;
          act_o.send_data = 1'b1;
          act_o.fan_cnt   = 1'b1;
          nxt_o           = LS_V;
          cnt_op_o        = CN_CLR;
        end else if (cur_i == LS_A) begin
          act_o.tag_rd    = 1'b1;
          act_o.send_data = 1'b1;
          if (cnt_i <= CNT_W'(1)) begin
            nxt_o    = LS_I;
            cnt_op_o = CN_CLR;
          end else begin
            cnt_op_o = CN_DEC;
          end
        end
      end
      EV_WACK: begin
        act_o.pop = 1'b1;
        if (cur_i == LS_WI) begin
          nxt_o    = LS_I;
          cnt_op_o = CN_CLR;
        end else if (!dirty) begin
          act_o.ack = 1'b1;
        end
      end
      EV_READ: begin
        case (cur_i)
          LS_M, LS_V: begin
            act_o.pop       = 1'b1;
            act_o.tag_rd    = 1'b1;
            act_o.send_data = 1'b1;
            act_o.mru       = 1'b1;
          end
          LS_W: begin
            act_o.tag_rd = 1'b1;
            act_o.wb     = 1'b1;
            nxt_o        = LS_WI;
            cnt_op_o     = CN_CLR;
          end
          LS_I: begin
            act_o.pop    = 1'b1;
            act_o.tag_rd = 1'b1;
            act_o.down   = DN_READ;
            nxt_o        = LS_IV;
            cnt_op_o     = CN_ONE;
          end
          LS_IV: begin
            act_o.pop = 1'b1;
            cnt_op_o  = CN_INC;
          end
          default: act_o.stall = 1'b1;
        endcase
      end
      EV_ATOM: begin
        case (cur_i)
          LS_I, LS_V: begin
            act_o.pop    = 1'b1;
            act_o.tag_rd = 1'b1;
            act_o.inval  = (cur_i == LS_V);
            act_o.down   = DN_ATOM;
            nxt_o        = LS_A;
            cnt_op_o     = CN_ONE;
          end
          LS_A: begin
            act_o.pop  = 1'b1;
            act_o.down = DN_ATOM;
            cnt_op_o   = CN_INC;
          end
          LS_M, LS_W: begin
            act_o.tag_rd = 1'b1;
            act_o.wb     = 1'b1;
            nxt_o        = LS_WI;
            cnt_op_o     = CN_CLR;
          end
          default: act_o.stall = 1'b1;
        endcase
      end
      EV_WRITE: begin
        if (busy) begin
          act_o.stall = 1'b1;
        end else if (wb_mode_i) begin
          act_o.pop    = 1'b1;
          act_o.tag_rd = 1'b1;
          act_o.ack    = 1'b1;
          act_o.merge  = 1'b1;
          act_o.mru    = 1'b1;
          if (cur_i == LS_I) begin
            act_o.alloc = 1'b1;
            nxt_o       = LS_W;
          end else if (cur_i != LS_W) begin
            nxt_o = LS_M;
          end
        end else begin
          act_o.pop    = 1'b1;
          act_o.tag_rd = 1'b1;
          act_o.down   = DN_WRITE;
          if (cur_i != LS_I) begin
            act_o.merge = 1'b1;
            act_o.mru   = 1'b1;
          end
        end
      end
      EV_REPL: begin
        if (dirty) begin
          act_o.tag_rd = 1'b1;
          act_o.wb     = 1'b1;
          act_o.inval  = 1'b1;
          nxt_o        = LS_WI;
          cnt_op_o     = CN_CLR;
        end else if (cur_i == LS_V) begin
          act_o.tag_rd = 1'b1;
          act_o.inval  = 1'b1;
          nxt_o        = LS_I;
        end else if (cur_i == LS_I) begin
          act_o.tag_rd = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/gl2_line_store.sv
module gl2_line_store
  import gl2_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int CNT_W     = 4,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] rd_line_i,
  output lstate_e           rd_state_o,
  output logic [CNT_W-1:0]  rd_cnt_o,
  input  logic              we_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  lstate_e           wr_state_i,
  input  logic [CNT_W-1:0]  wr_cnt_i
);

  lstate_e          st_arr  [NUM_LINES];
  logic [CNT_W-1:0] cnt_arr [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    lstate_e          st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             en;

    assign en = we_i && (wr_line_i == LINE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q  <= LS_I;
        cnt_q <= '0;
      end else if (en) begin
        st_q  <= wr_state_i;
        cnt_q <= wr_cnt_i;
      end
    end

    assign st_arr[g]  = st_q;
    assign cnt_arr[g] = cnt_q;
  end

  assign rd_state_o = st_arr[rd_line_i];
  assign rd_cnt_o   = cnt_arr[rd_line_i];

endmodule

// File: rtl/gl2_line_ctrl.sv
module gl2_line_ctrl
  import gl2_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int CNT_W     = 4,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_mode_i,
  input  logic              prb_valid_i,
  input  logic [LINE_W-1:0] prb_line_i,
  input  logic              rsp_valid_i,
  input  logic              rsp_ack_i,
  input  logic [LINE_W-1:0] rsp_line_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic [LINE_W-1:0] req_line_i,
  input  logic              req_room_i,
  input  logic [LINE_W-1:0] req_victim_i,
  output logic [LINE_W-1:0] evt_line_o,
  output logic [2:0]        cur_state_o,
  output logic [2:0]        nxt_state_o,
  output logic              pop_prb_o,
  output logic              pop_rsp_o,
  output logic              pop_req_o,
  output logic              stall_o,
  output logic              repl_o,
  output logic              tag_rd_o,
  output logic              send_data_o,
  output logic [CNT_W-1:0]  fanout_o,
  output logic              ack_client_o,
  output logic [1:0]        down_kind_o,
  output logic              wb_o,
  output logic              inval_o,
  output logic              alloc_o,
  output logic              merge_o,
  output logic              fill_wr_o,
  output logic              mru_o,
  output logic              prb_reply_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  evt_e              evt;
  src_e              src;
  logic [LINE_W-1:0] line;
  lstate_e           cur_st;
  lstate_e           nxt_st;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_nxt;
  cnt_op_e           cnt_op;
  act_t              act;
  logic              commit;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  gl2_evt_sel #(.LINE_W(LINE_W)) u_sel (
    .wb_mode_i   (wb_mode_i),
    .prb_valid_i (prb_valid_i),
    .prb_line_i  (prb_line_i),
    .rsp_valid_i (rsp_valid_i),
    .rsp_ack_i   (rsp_ack_i),
    .rsp_line_i  (rsp_line_i),
    .req_valid_i (req_valid_i),
    .req_kind_i  (req_kind_i),
    .req_line_i  (req_line_i),
    .req_room_i  (req_room_i),
    .req_victim_i(req_victim_i),
    .evt_o       (evt),
    .src_o       (src),
    .line_o      (line)
  );

  gl2_line_fsm #(.CNT_W(CNT_W)) u_fsm (
    .evt_i    (evt),
    .cur_i    (cur_st),
    .cnt_i    (cnt),
    .wb_mode_i(wb_mode_i),
    .nxt_o    (nxt_st),
    .act_o    (act),
    .cnt_op_o (cnt_op)
  );

  always_comb begin
    case (cnt_op)
      CN_ONE:  cnt_nxt = CNT_W'(1);
      CN_INC:  cnt_nxt = cnt + CNT_W'(1);
      CN_DEC:  cnt_nxt = cnt - CNT_W'(1);
      CN_CLR:  cnt_nxt = '0;
      default: cnt_nxt = cnt;
    endcase
  end

  assign commit = (evt != EV_NONE) && !act.stall;

  gl2_line_store #(.NUM_LINES(NUM_LINES), .CNT_W(CNT_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rd_line_i (line),
    .rd_state_o(cur_st),
    .rd_cnt_o  (cnt),
    .we_i      (commit),
    .wr_line_i (line),
    .wr_state_i(nxt_st),
    .wr_cnt_i  (cnt_nxt)
  );

  assign evt_line_o   = line;
  assign cur_state_o  = cur_st;
  assign nxt_state_o  = nxt_st;
  assign pop_prb_o    = act.pop && (src == SRC_PRB);
  assign pop_rsp_o    = act.pop && (src == SRC_RSP);
  assign pop_req_o    = act.pop && (src == SRC_REQ);
  assign stall_o      = act.stall;
  assign repl_o       = (evt == EV_REPL);
  assign tag_rd_o     = act.tag_rd;
  assign send_data_o  = act.send_data;
  assign fanout_o     = !act.send_data ? '0 : (act.fan_cnt ? cnt : CNT_W'(1));
  assign ack_client_o = act.ack;
  assign down_kind_o  = act.down;
  assign wb_o         = act.wb;
  assign inval_o      = act.inval;
  assign alloc_o      = act.alloc;
  assign merge_o      = act.merge;
  assign fill_wr_o    = act.fill_wr;
  assign mru_o        = act.mru;
  assign prb_reply_o  = act.prb_reply;

endmodule

// File: rtl/gl2_line_ctrl_chk.sv
module gl2_line_ctrl_chk #(
  parameter int LINE_W = 4,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prb_valid_i,
  input logic              rsp_valid_i,
  input logic              req_valid_i,
  input logic [LINE_W-1:0] evt_line_o,
  input logic [2:0]        cur_state_o,
  input logic [2:0]        nxt_state_o,
  input logic              pop_prb_o,
  input logic              pop_rsp_o,
  input logic              pop_req_o,
  input logic              stall_o,
  input logic              repl_o,
  input logic              tag_rd_o,
  input logic              send_data_o,
  input logic [1:0]        down_kind_o,
  input logic              wb_o,
  input logic              prb_reply_o
);

  logic ev_any;
  assign ev_any = pop_prb_o || pop_rsp_o || pop_req_o || repl_o;

  p_one_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pop_prb_o, pop_rsp_o, pop_req_o}));

  p_probe_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prb_valid_i |-> (pop_prb_o && prb_reply_o));

  p_rsp_second_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_i && !prb_valid_i) |-> pop_rsp_o);

  p_req_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req_o |-> (!prb_valid_i && !rsp_valid_i));

  p_probe_no_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_prb_o |-> (!send_data_o && !wb_o && down_kind_o == 2'd0));

  p_stall_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (!tag_rd_o && !pop_req_o && nxt_state_o == cur_state_o));

  p_repl_holds_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    repl_o |-> (!pop_req_o && !stall_o));

  p_state_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_any |=> (!ev_any || evt_line_o != $past(evt_line_o) ||
                cur_state_o == $past(nxt_state_o)));

endmodule

bind gl2_line_ctrl gl2_line_ctrl_chk #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/gl2_line_ctrl_bench.sv
module gl2_line_ctrl_bench;

  typedef struct packed {
    logic [3:0] line;
    logic [2:0] cur;
    logic [2:0] nxt;
    logic       pp, pr, pq, stall, repl, tag, sd;
    logic [3:0] fan;
    logic       ack;
    logic [1:0] down;
    logic       wb, inval, alloc, merge, fill, mru, reply;
  } exp_t;

  localparam logic [2:0] S_I = 3'd0, S_V = 3'd1, S_M = 3'd2, S_W = 3'd3,
                         S_IV = 3'd4, S_WI = 3'd5, S_A = 3'd6;
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_AT = 2'd2;

  logic       clk, rst_n, wb_mode;
  logic       prb_valid, rsp_valid, rsp_ack, req_valid, req_room;
  logic [3:0] prb_line, rsp_line, req_line, req_victim;
  logic [1:0] req_kind;
  logic [3:0] evt_line, fanout;
  logic [2:0] cur_state, nxt_state;
  logic       pop_prb, pop_rsp, pop_req, stall, repl, tag_rd, send_data;
  logic       ack_client, wb, inval, alloc, merge, fill_wr, mru, prb_reply;
  logic [1:0] down_kind;

  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  gl2_line_ctrl #(.NUM_LINES(16), .CNT_W(4)) u_gl2_line_ctrl (
    .clk(clk), .rst_n(rst_n), .wb_mode_i(wb_mode),
    .prb_valid_i(prb_valid), .prb_line_i(prb_line),
    .rsp_valid_i(rsp_valid), .rsp_ack_i(rsp_ack), .rsp_line_i(rsp_line),
    .req_valid_i(req_valid), .req_kind_i(req_kind), .req_line_i(req_line),
    .req_room_i(req_room), .req_victim_i(req_victim),
    .evt_line_o(evt_line), .cur_state_o(cur_state), .nxt_state_o(nxt_state),
    .pop_prb_o(pop_prb), .pop_rsp_o(pop_rsp), .pop_req_o(pop_req),
    .stall_o(stall), .repl_o(repl), .tag_rd_o(tag_rd), .send_data_o(send_data),
    .fanout_o(fanout), .ack_client_o(ack_client), .down_kind_o(down_kind),
    .wb_o(wb), .inval_o(inval), .alloc_o(alloc), .merge_o(merge),
    .fill_wr_o(fill_wr), .mru_o(mru), .prb_reply_o(prb_reply)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic exp_t ex(logic [3:0] l, logic [2:0] c, logic [2:0] n);
    exp_t e;
    e = '0;
    e.line = l;
    e.cur  = c;
    e.nxt  = n;
    return e;
  endfunction

  // Monitor: compares the combinational result mid-cycle
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      exp_t  a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {evt_line, cur_state, nxt_state, pop_prb, pop_rsp, pop_req, stall,
           repl, tag_rd, send_data, fanout, ack_client, down_kind, wb, inval,
           alloc, merge, fill_wr, mru, prb_reply};
      n_checks++;
      if (a !== e) begin
        n_fails++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic clear_inputs();
    prb_valid = 0; prb_line = 0; rsp_valid = 0; rsp_ack = 0; rsp_line = 0;
    req_valid = 0; req_kind = 0; req_line = 0; req_room = 0; req_victim = 0;
  endtask

  task automatic step(input logic pv, input logic [3:0] pl,
                      input logic rv, input logic rk, input logic [3:0] rl,
                      input logic qv, input logic [1:0] qk, input logic [3:0] ql,
                      input logic qr, input logic [3:0] qvic,
                      input exp_t e, input string t);
    @(posedge clk); #1;
    prb_valid = pv; prb_line = pl;
    rsp_valid = rv; rsp_ack = rk; rsp_line = rl;
    req_valid = qv; req_kind = qk; req_line = ql; req_room = qr; req_victim = qvic;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic prb(input logic [3:0] l, input exp_t e, input string t);
    step(1, l, 0, 0, 0, 0, 0, 0, 0, 0, e, t);
  endtask
  task automatic rsp(input logic k, input logic [3:0] l, input exp_t e, input string t);
    step(0, 0, 1, k, l, 0, 0, 0, 0, 0, e, t);
  endtask
  task automatic req(input logic [1:0] k, input logic [3:0] l, input logic room,
                     input logic [3:0] vic, input exp_t e, input string t);
    step(0, 0, 0, 0, 0, 1, k, l, room, vic, e, t);
  endtask
  task automatic idle_cycle();
    @(posedge clk); #1;
    clear_inputs();
  endtask

  initial begin
    exp_t e;
    rst_n = 0; wb_mode = 0;
    clear_inputs();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);

    // R1 reset state, idle
    e = ex(0, S_I, S_I);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, e, "R1 idle after reset");
    // R9 probe on I
    e = ex(3, S_I, S_I); e.pp = 1; e.tag = 1; e.reply = 1;
    prb(3, e, "R9 probe in I");
    // R4 read miss
    e = ex(2, S_I, S_IV); e.pq = 1; e.tag = 1; e.down = 1;
    req(K_RD, 2, 1, 0, e, "R4 read miss");
    e = ex(2, S_IV, S_IV); e.pq = 1;
    req(K_RD, 2, 1, 0, e, "R4 second read in IV");
    // R10 stalls in IV
    e = ex(2, S_IV, S_IV); e.stall = 1;
    req(K_WR, 2, 1, 0, e, "R10 write stalls in IV");
    e = ex(2, S_IV, S_IV); e.stall = 1;
    req(K_AT, 2, 1, 0, e, "R10 atomic stalls in IV");
    // R4 / R2 fill wins over a pending read
    e = ex(2, S_IV, S_V); e.pr = 1; e.tag = 1; e.sd = 1; e.fan = 2;
    e.alloc = 1; e.fill = 1; e.mru = 1;
    step(0, 0, 1, 0, 2, 1, K_RD, 7, 1, 0, e, "R4 R2 fill to two waiters");
    // R3 read hit V
    e = ex(2, S_V, S_V); e.pq = 1; e.tag = 1; e.sd = 1; e.fan = 1; e.mru = 1;
    req(K_RD, 2, 1, 0, e, "R3 read hit V");
    // R6 write-through
    e = ex(2, S_V, S_V); e.pq = 1; e.tag = 1; e.merge = 1; e.mru = 1; e.down = 2;
    req(K_WR, 2, 1, 0, e, "R6 write in V");
    e = ex(9, S_I, S_I); e.pq = 1; e.tag = 1; e.down = 2;
    req(K_WR, 9, 1, 0, e, "R6 write in I");
    // R2 / R9 probe wins over everything
    e = ex(2, S_V, S_I); e.pp = 1; e.tag = 1; e.inval = 1; e.reply = 1;
    step(1, 2, 1, 0, 13, 1, K_RD, 7, 1, 0, e, "R2 R9 probe priority on V");
    // R11 relay in I
    e = ex(9, S_I, S_I); e.pr = 1; e.ack = 1;
    rsp(1, 9, e, "R11 ack relayed in I");
    // R5 atomics
    e = ex(4, S_I, S_A); e.pq = 1; e.tag = 1; e.down = 3;
    req(K_AT, 4, 1, 0, e, "R5 atomic in I");
    e = ex(4, S_A, S_A); e.pq = 1; e.down = 3;
    req(K_AT, 4, 1, 0, e, "R5 atomic in A");
    e = ex(4, S_A, S_A); e.stall = 1;
    req(K_RD, 4, 1, 0, e, "R10 read stalls in A");
    e = ex(4, S_A, S_A); e.pr = 1; e.tag = 1; e.sd = 1; e.fan = 1;
    rsp(0, 4, e, "R5 first atomic result");
    e = ex(4, S_A, S_A); e.pp = 1; e.reply = 1;
    prb(4, e, "R9 probe leaves A");
    e = ex(4, S_A, S_I); e.pr = 1; e.tag = 1; e.sd = 1; e.fan = 1;
    rsp(0, 4, e, "R5 last atomic result");

    idle_cycle();
    wb_mode = 1;

    // R7 write-back writes
    e = ex(5, S_I, S_W); e.pq = 1; e.tag = 1; e.ack = 1; e.merge = 1; e.mru = 1; e.alloc = 1;
    req(K_WR, 5, 1, 0, e, "R7 write in I");
    e = ex(5, S_W, S_W); e.pq = 1; e.tag = 1; e.ack = 1; e.merge = 1; e.mru = 1;
    req(K_WR, 5, 1, 0, e, "R7 write in W");
    // R3 read in W
    e = ex(5, S_W, S_WI); e.tag = 1; e.wb = 1;
    req(K_RD, 5, 1, 0, e, "R3 read in W writes back");
    e = ex(5, S_WI, S_WI); e.stall = 1;
    req(K_RD, 5, 1, 0, e, "R10 read stalls in WI");
    e = ex(5, S_WI, S_I); e.pr = 1;
    rsp(1, 5, e, "R11 ack in WI");
    e = ex(6, S_I, S_W); e.pq = 1; e.tag = 1; e.ack = 1; e.merge = 1; e.mru = 1; e.alloc = 1;
    req(K_WR, 6, 1, 0, e, "R7 write in I line 6");
    e = ex(6, S_W, S_W); e.pp = 1; e.tag = 1; e.reply = 1;
    prb(6, e, "R9 probe keeps W");
    e = ex(8, S_I, S_IV); e.pq = 1; e.tag = 1; e.down = 1;
    req(K_RD, 8, 1, 0, e, "R4 read miss line 8");
    e = ex(8, S_IV, S_V); e.pr = 1; e.tag = 1; e.sd = 1; e.fan = 1;
    e.alloc = 1; e.fill = 1; e.mru = 1;
    rsp(0, 8, e, "R4 fill single waiter");
    e = ex(8, S_V, S_M); e.pq = 1; e.tag = 1; e.ack = 1; e.merge = 1; e.mru = 1;
    req(K_WR, 8, 1, 0, e, "R7 write in V");
    e = ex(8, S_M, S_M); e.pq = 1; e.tag = 1; e.sd = 1; e.fan = 1; e.mru = 1;
    req(K_RD, 8, 1, 0, e, "R3 read hit M");
    e = ex(8, S_M, S_W); e.pp = 1; e.tag = 1; e.reply = 1;
    prb(8, e, "R9 probe M to W");
    // R8 replacement
    e = ex(8, S_W, S_WI); e.repl = 1; e.tag = 1; e.wb = 1; e.inval = 1;
    req(K_WR, 11, 0, 8, e, "R8 replace dirty victim");
    e = ex(2, S_I, S_I); e.repl = 1; e.tag = 1;
    req(K_WR, 11, 0, 2, e, "R8 replace invalid victim");
    // R5 atomic on dirty line
    e = ex(6, S_W, S_WI); e.tag = 1; e.wb = 1;
    req(K_AT, 6, 1, 0, e, "R5 atomic in W writes back");
    e = ex(6, S_WI, S_I); e.pr = 1;
    rsp(1, 6, e, "R11 ack in WI line 6");
    e = ex(8, S_WI, S_I); e.pr = 1;
    rsp(1, 8, e, "R11 ack in WI line 8");
    e = ex(3, S_I, S_I); e.pr = 1; e.ack = 1;
    rsp(1, 3, e, "R11 ack relayed line 3");
    e = ex(0, S_I, S_I);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, e, "R1 idle at end");

    idle_cycle();
    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_fails++;
      $display("FAIL R1: actual %0d pending results expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fails++;
      $display("FAIL R1: watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule